// File: doc/BRIEF.md
# Bit-Field Insert and Extract Unit

This unit moves a bit field between a 16-bit data register and memory organised as 16-bit little-endian words. A field is between 1 and 16 bits long. Its start is a bit offset from 0 to 15, counted from bit 0 of the word the pointer selects. When the field runs past bit 15 of that word, it continues into the next word. An insert merges the low bits of the source data into memory. An extract returns the field right-aligned in a result register.

A call is started with a one-cycle `start` pulse. The unit then issues word reads and writes on a simple memory port, one request at a time, and ends with a one-cycle `done` pulse. Along with `done` it returns the updated byte pointer and bit offset. Feeding these back into the next call walks through a packed stream of fields with no external arithmetic. For an insert, a word is read only when it holds bits that must survive the write.

Top module: `bfx_unit`

## Requirements
- R1: Field length is `len_code + 1` (1 to 16 bits). An extract places memory bit `ofs_in + i` of the two-word window (word at `ptr_in` is bits 0..15, word at `ptr_in + 2` is bits 16..31) into `field_out[i]`. Every `field_out` bit at or above the length is zero. An insert leaves `field_out` unchanged.
- R2: With `end = ofs_in + length`, the call touches only the word at `ptr_in` when end <= 16. It touches the words at `ptr_in` and `ptr_in + 2` when end > 16.
- R3: An insert does not read the first word when the field covers all 16 of its bits (offset 0, length 16). Otherwise the first word is read before it is written.
- R4: An insert that spans two words reads the second word before writing it, because that word always keeps some bits above the field.
- R5: An insert writes source bit `i` to window bit `ofs_in + i` for every i below the length, and leaves every other memory bit unchanged.
- R6: On `done`, `ofs_out = (ofs_in + length) mod 16`, and `ptr_out = ptr_in + 2` when `ofs_in + length >= 16`; otherwise `ptr_out = ptr_in`. This holds for both operations.
- R7: An extract never writes memory.
- R8: `mem_req` is a one-cycle pulse. After a read request, no further request is issued until `mem_rvalid` has returned the data. A write completes in its request cycle. `done` is high for exactly one cycle per call.
- R9: Memory is accessed in this order: reads before writes, and the word at `ptr_in` before the word at `ptr_in + 2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a call; sampled only while idle |
| op_insert | input | 1 | 1 = insert, 0 = extract |
| ptr_in | input | AW | Byte address of the first word |
| ofs_in | input | 4 | Bit offset of the field in the first word |
| len_code | input | 4 | Field length minus one |
| src_data | input | 16 | Source data for an insert; the field is its low bits |
| mem_req | output | 1 | Memory request pulse |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | AW | Byte address of the requested word |
| mem_wdata | output | 16 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| done | output | 1 | Call complete (one cycle) |
| ptr_out | output | AW | Advanced pointer |
| ofs_out | output | 4 | Advanced bit offset |
| field_out | output | 16 | Extracted field, right-aligned |

## Verification
The in-line assertions check four rules on every cycle:
- a read request is never followed directly by another request;
- `done` never lasts two cycles;
- an extract never raises a write;
- at completion, the number of reads and writes the unit issued matches what the field geometry calls for.

The directed scenarios are the only way to show the data results: merged memory contents with neighbouring bits preserved, right-aligned and zero-filled extract values, and correctly advanced pointer and offset across a chain of fields. These are compared against a bit-by-bit model of the window.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam int DW = 16;
  localparam int OW = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_PLAN, S_RD0, S_RD0W, S_RD1, S_RD1W, S_WR0, S_WR1, S_FIN, S_DONE
  } bfx_state_e;

  // field length in bits, 1..16
  function automatic logic [OW:0] fld_len(input logic [OW-1:0] code);
    return {1'b0, code} + {{OW{1'b0}}, 1'b1};
  endfunction

  // first bit position past the field, 1..31
  function automatic logic [OW+1:0] fld_end(input logic [OW-1:0] ofs,
                                            input logic [OW-1:0] code);
    return {2'b00, ofs} + {1'b0, fld_len(code)};
  endfunction

  // right-aligned ones covering the field length
  function automatic logic [DW-1:0] len_mask(input logic [OW-1:0] code);
    return {DW{1'b1}} >> (OW'(DW - 1) - code);
  endfunction

  // field mask placed in the two-word window
  function automatic logic [2*DW-1:0] win_mask(input logic [OW-1:0] ofs,
                                               input logic [OW-1:0] code);
    return {{DW{1'b0}}, len_mask(code)} << ofs;
  endfunction
endpackage

// File: rtl/bfx_geom.sv
module bfx_geom
  import bfx_pkg::*;
(
  input  logic [OW-1:0] ofs,
  input  logic [OW-1:0] code,
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] w0,
  input  logic [DW-1:0] w1,
  output logic          two,
  output logic          adv,
  output logic [OW-1:0] new_ofs,
  output logic          need_rd0,
  output logic [DW-1:0] wr0,
  output logic [DW-1:0] wr1,
  output logic [DW-1:0] ext_val
);
  logic [OW+1:0]   end_pos;
  logic [2*DW-1:0] msk;
  logic [2*DW-1:0] ins_win;
  logic [2*DW-1:0] ext_win;

  always_comb begin
    end_pos  = fld_end(ofs, code);
    two      = end_pos > (OW+2)'(DW);
    adv      = end_pos >= (OW+2)'(DW);
    new_ofs  = end_pos[OW-1:0];
    msk      = win_mask(ofs, code);
    need_rd0 = msk[DW-1:0] != {DW{1'b1}};
    ins_win  = {{DW{1'b0}}, data & len_mask(code)} << ofs;
    wr0      = (w0 & ~msk[DW-1:0])    | ins_win[DW-1:0];
    wr1      = (w1 & ~msk[2*DW-1:DW]) | ins_win[2*DW-1:DW];
    ext_win  = {w1, w0} >> ofs;
    ext_val  = ext_win[DW-1:0] & len_mask(code);
  end
endmodule

// File: rtl/bfx_ctrl.sv
module bfx_ctrl
  import bfx_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_insert,
  input  logic [AW-1:0] ptr_in,
  input  logic [OW-1:0] ofs_in,
  input  logic [OW-1:0] len_code,
  input  logic [DW-1:0] src_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic [AW-1:0] ptr_out,
  output logic [OW-1:0] ofs_out,
  output logic [DW-1:0] field_out,
  // towards geometry
  output logic [OW-1:0] ofs_q,
  output logic [OW-1:0] code_q,
  output logic [DW-1:0] data_q,
  output logic [DW-1:0] w0_q,
  output logic [DW-1:0] w1_q,
  input  logic          two,
  input  logic          adv,
  input  logic [OW-1:0] new_ofs,
  input  logic          need_rd0,
  input  logic [DW-1:0] wr0,
  input  logic [DW-1:0] wr1,
  input  logic [DW-1:0] ext_val
);
  localparam logic [AW-1:0] WSTEP = AW'(DW / 8);

  bfx_state_e st, st_nx;
  logic          op_q;
  logic [AW-1:0] ptr_q;
  logic [1:0]    rd_cnt, wr_cnt;

  // named events for the checks
  logic second_word, rd_issue, wr_issue;

  always_comb begin
    second_word = (st == S_RD1) || (st == S_WR1);
    rd_issue    = (st == S_RD0) || (st == S_RD1);
    wr_issue    = (st == S_WR0) || (st == S_WR1);
    mem_req     = rd_issue || wr_issue;
    mem_we      = wr_issue;
    mem_addr    = second_word ? ptr_q + WSTEP : ptr_q;
    mem_wdata   = (st == S_WR1) ? wr1 : wr0;
    done        = (st == S_DONE);
  end

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE: if (start) st_nx = S_PLAN;
      S_PLAN: begin
        if (!op_q || need_rd0) st_nx = S_RD0;
        else if (two)          st_nx = S_RD1;
        else                   st_nx = S_WR0;
      end
      S_RD0:  st_nx = S_RD0W;
      S_RD0W: if (mem_rvalid) st_nx = two ? S_RD1 : (op_q ? S_WR0 : S_FIN);
      S_RD1:  st_nx = S_RD1W;
      S_RD1W: if (mem_rvalid) st_nx = op_q ? S_WR0 : S_FIN;
      S_WR0:  st_nx = two ? S_WR1 : S_FIN;
      S_WR1:  st_nx = S_FIN;
      S_FIN:  st_nx = S_DONE;
      S_DONE: st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      op_q      <= 1'b0;
      ptr_q     <= '0;
      ofs_q     <= '0;
      code_q    <= '0;
      data_q    <= '0;
      w0_q      <= '0;
      w1_q      <= '0;
      ptr_out   <= '0;
      ofs_out   <= '0;
      field_out <= '0;
      rd_cnt    <= '0;
      wr_cnt    <= '0;
    end else begin
      st <= st_nx;
      if (st == S_IDLE && start) begin
        op_q   <= op_insert;
        ptr_q  <= ptr_in;
        ofs_q  <= ofs_in;
        code_q <= len_code;
        data_q <= src_data;
        rd_cnt <= '0;
        wr_cnt <= '0;
      end
      if (rd_issue) rd_cnt <= rd_cnt + 2'd1;
      if (wr_issue) wr_cnt <= wr_cnt + 2'd1;
      if (st == S_RD0W && mem_rvalid) w0_q <= mem_rdata;
      if (st == S_RD1W && mem_rvalid) w1_q <= mem_rdata;
      if (st == S_FIN) begin
        ptr_out <= adv ? ptr_q + WSTEP : ptr_q;
        ofs_out <= new_ofs;
        if (!op_q) field_out <= ext_val;
      end
    end
  end

  // R7
  ext_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !op_q && st != S_IDLE) |-> !mem_we);

  // R8
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> !mem_req);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  ext_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !op_q) |-> (rd_cnt == (two ? 2'd2 : 2'd1) && wr_cnt == 2'd0));

  // R3
  ins_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q) |-> (rd_cnt == {1'b0, need_rd0} + {1'b0, two}));

  // R4
  ins_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q) |-> (wr_cnt == (two ? 2'd2 : 2'd1)));
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_insert,
  input  logic [AW-1:0] ptr_in,
  input  logic [3:0]    ofs_in,
  input  logic [3:0]    len_code,
  input  logic [15:0]   src_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic          mem_rvalid,
  input  logic [15:0]   mem_rdata,
  output logic          done,
  output logic [AW-1:0] ptr_out,
  output logic [3:0]    ofs_out,
  output logic [15:0]   field_out
);
  logic [OW-1:0] ofs_q, code_q, new_ofs;
  logic [DW-1:0] data_q, w0_q, w1_q, wr0, wr1, ext_val;
  logic          two, adv, need_rd0;

  bfx_geom u_geom (
    .ofs(ofs_q), .code(code_q), .data(data_q), .w0(w0_q), .w1(w1_q),
    .two(two), .adv(adv), .new_ofs(new_ofs), .need_rd0(need_rd0),
    .wr0(wr0), .wr1(wr1), .ext_val(ext_val)
  );

  bfx_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op_insert(op_insert),
    .ptr_in(ptr_in), .ofs_in(ofs_in), .len_code(len_code), .src_data(src_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done),
    .ptr_out(ptr_out), .ofs_out(ofs_out), .field_out(field_out),
    .ofs_q(ofs_q), .code_q(code_q), .data_q(data_q), .w0_q(w0_q), .w1_q(w1_q),
    .two(two), .adv(adv), .new_ofs(new_ofs), .need_rd0(need_rd0),
    .wr0(wr0), .wr1(wr1), .ext_val(ext_val)
  );
endmodule

// File: tb/tb_bfx_unit.sv
`timescale 1ns/1ps
module tb_bfx_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, op_insert = 1'b0;
  logic [15:0] ptr_in = '0, src_data = '0;
  logic [3:0]  ofs_in = '0, len_code = '0;
  logic        mem_req, mem_we, done;
  logic [15:0] mem_addr, mem_wdata, ptr_out, field_out;
  logic [3:0]  ofs_out;
  logic        mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  bfx_unit #(.AW(16)) dut (.*);

  logic [15:0] tmem [64];
  logic [15:0] em   [64];
  int rd_n, wr_n, pend, total, bad;
  int first_wr_addr, last_rd_addr;
  bit wr_before_rd;
  logic [5:0] paddr;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (pend != 0) begin
      pend <= pend - 1;
      if (pend == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= tmem[paddr];
      end
    end
    if (mem_req) begin
      if (mem_we) begin
        tmem[mem_addr[6:1]] <= mem_wdata;
        if (wr_n == 0) first_wr_addr = mem_addr;
        wr_n++;
      end else begin
        if (wr_n != 0) wr_before_rd = 1'b1;
        last_rd_addr = mem_addr;
        pend  <= 2;
        paddr <= mem_addr[6:1];
        rd_n++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one call; outputs sampled at the negedge where done is high
  task automatic run_op(input bit ins, input logic [15:0] p, input logic [3:0] o,
                        input logic [3:0] c, input logic [15:0] d);
    int n;
    @(negedge clk);
    rd_n = 0; wr_n = 0; wr_before_rd = 1'b0;
    op_insert = ins; ptr_in = p; ofs_in = o; len_code = c; src_data = d;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL R8 call did not finish actual=0 expected=1");
    end
  endtask

  // full independent check of one call against a bit-level model
  task automatic do_case(input string tag, input bit ins, input logic [15:0] p,
                         input logic [3:0] o, input logic [3:0] c, input logic [15:0] d);
    int len, fin, base;
    int exp_rd, exp_wr;
    logic [15:0] old_field, exp_field;
    old_field = field_out;
    len  = c + 1;
    fin  = o + len;
    base = p[6:1];
    exp_field = '0;
    for (int i = 0; i < len; i++) begin
      int pos = o + i;
      exp_field[i] = em[(base + pos / 16) % 64][pos % 16];
      if (ins) em[(base + pos / 16) % 64][pos % 16] = d[i];
    end
    run_op(ins, p, o, c, d);
    // R6
    chk({tag, " R6 ptr"}, ptr_out, (fin >= 16) ? p + 16'd2 : p);
    chk({tag, " R6 ofs"}, ofs_out, fin % 16);
    if (ins) begin
      exp_rd = ((o == 0 && len == 16) ? 0 : 1) + ((fin > 16) ? 1 : 0);
      exp_wr = (fin > 16) ? 2 : 1;
      // R3 / R4
      chk({tag, " R3 R4 reads"}, rd_n, exp_rd);
      chk({tag, " R2 writes"}, wr_n, exp_wr);
      // R1 insert leaves result register alone
      chk({tag, " R1 field held"}, field_out, old_field);
      // R9
      chk({tag, " R9 order"}, wr_before_rd, 0);
      chk({tag, " R9 first write addr"}, first_wr_addr, p);
    end else begin
      // R1
      chk({tag, " R1 field"}, field_out, exp_field);
      // R2 / R7
      chk({tag, " R2 reads"}, rd_n, (fin > 16) ? 2 : 1);
      chk({tag, " R7 writes"}, wr_n, 0);
      chk({tag, " R9 last read addr"}, last_rd_addr, (fin > 16) ? p + 16'd2 : p);
    end
    // R5
    begin
      int diff = 0;
      for (int k = 0; k < 64; k++) if (tmem[k] !== em[k]) diff++;
      chk({tag, " R5 memory"}, diff, 0);
    end
    @(negedge clk);
    // R8
    chk({tag, " R8 done pulse"}, done, 0);
  endtask

  task automatic t_reset;
    chk("R8 reset done", done, 0);
    chk("R8 reset req", mem_req, 0);
    chk("R6 reset ptr", ptr_out, 0);
  endtask

  task automatic t_ext_single;
    tmem[4] = 16'hA5C3; em[4] = 16'hA5C3;
    do_case("ext_single", 0, 16'h0008, 4'd4, 4'd7, 16'h0);
    chk("R1 ext_single value", field_out, 16'h005C);
  endtask

  task automatic t_ext_span;
    tmem[6] = 16'hB000; em[6] = 16'hB000;
    tmem[7] = 16'h0007; em[7] = 16'h0007;
    do_case("ext_span", 0, 16'h000C, 4'd12, 4'd7, 16'h0);
    chk("R1 ext_span value", field_out, 16'h007B);
  endtask

  task automatic t_ext_edges;
    do_case("ext_full", 0, 16'h0010, 4'd0, 4'd15, 16'h0);
    do_case("ext_top_bit", 0, 16'h0012, 4'd15, 4'd0, 16'h0);
    do_case("ext_max_span", 0, 16'h0014, 4'd15, 4'd15, 16'h0);
  endtask

  task automatic t_ins_full;
    do_case("ins_full", 1, 16'h0020, 4'd0, 4'd15, 16'hBEEF);
    chk("R3 ins_full word", tmem[16], 16'hBEEF);
  endtask

  task automatic t_ins_inner;
    tmem[17] = 16'hFFFF; em[17] = 16'hFFFF;
    do_case("ins_inner", 1, 16'h0022, 4'd4, 4'd3, 16'hFFF0);
    chk("R5 ins_inner word", tmem[17], 16'hFF0F);
  endtask

  task automatic t_ins_span;
    do_case("ins_span", 1, 16'h0024, 4'd10, 4'd11, 16'h0ABC);
    do_case("ins_to_end", 1, 16'h0028, 4'd8, 4'd7, 16'h5A5A);
    do_case("ins_max_span", 1, 16'h002A, 4'd15, 4'd15, 16'h8001);
  endtask

  task automatic t_walk;
    logic [15:0] p, pw [5], lens;
    logic [3:0]  o, ow [5];
    logic [3:0]  codes [5];
    logic [15:0] vals [5];
    codes[0] = 4'd4;  codes[1] = 4'd8;  codes[2] = 4'd15; codes[3] = 4'd2;  codes[4] = 4'd11;
    vals[0]  = 16'h0015; vals[1] = 16'h01A3; vals[2] = 16'hC3D2; vals[3] = 16'h0005; vals[4] = 16'h0F0E;
    p = 16'h0040; o = 4'd3;
    for (int i = 0; i < 5; i++) begin
      pw[i] = p; ow[i] = o;
      do_case("walk_ins", 1, p, o, codes[i], vals[i]);
      p = ptr_out; o = ofs_out;
    end
    p = 16'h0040; o = 4'd3;
    for (int i = 0; i < 5; i++) begin
      do_case("walk_ext", 0, p, o, codes[i], 16'h0);
      lens = 16'hFFFF >> (15 - codes[i]);
      chk("R1 walk round trip", field_out, vals[i] & lens);
      chk("R6 walk chain ptr", p, pw[i]);
      chk("R6 walk chain ofs", o, ow[i]);
      p = ptr_out; o = ofs_out;
    end
  endtask

  initial begin
    for (int k = 0; k < 64; k++) begin
      tmem[k] = 16'(k * 16'h9E37) ^ 16'h5A5A;
      em[k]   = tmem[k];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ext_single();
    t_ext_span();
    t_ext_edges();
    t_ins_full();
    t_ins_inner();
    t_ins_span();
    t_walk();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R8 watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule